// File: doc/BRIEF.md
# Reset Controller with Pin Sequencer

This block turns three reset sources into one system reset and one CPU-release signal. A power-on reset input clears everything at once. An active-high external reset pin enters through a two-flop synchronizer. A watchdog expiry pulse acts only if firmware has turned the watchdog on. The block keeps a small status word that records which source caused the last reset, so firmware can find out why it restarted.

After a power-on or external reset, the block drives a two-pin handshake so that an outside programmer can lock onto the device's timing. For one phase of `PHASE_CYCLES` sleep-clock cycles, pin 0 is driven strong high and pin 1 resistive low. For a second phase of the same length, both pins are resistive low. After that, both pins float and the CPU is released. A watchdog reset skips this handshake: it holds the system in reset for one cycle and then releases the CPU again. While the CPU is held, all other GPIOs are asked to stay high-impedance.

The whole block runs on the slow sleep clock. Firmware writes the status word through a simple write strobe. The status bits are `[0]` power-on cause, `[1]` external cause, `[2]` watchdog cause and `[3]` watchdog enable.

Top module: `rstseq_top`

## Requirements
- R1: While `por_i` is high and in the cycle after it falls, `sys_rst_o`=1, `cpu_run_o`=0, `gpio_hiz_o`=1, `pin0_mode_o`=2'b10 (strong high) and `pin1_mode_o`=2'b01 (resistive low).
- R2: After `por_i` falls, the first handshake phase (pin0=2'b10, pin1=2'b01) lasts exactly `PHASE_CYCLES` rising edges.
- R3: The second phase (pin0=2'b01, pin1=2'b01) then lasts exactly `PHASE_CYCLES` rising edges.
- R4: After the second phase, both pins read 2'b00 (high-impedance), `cpu_run_o`=1, `sys_rst_o`=0 and `gpio_hiz_o`=0. `gpio_hiz_o` is 1 whenever `cpu_run_o` is 0.
- R5: A rise on `xres_i` shows on the outputs at the third rising edge after it. From then on, the status word gets bit 1 set with the other cause bits kept. The sequencer is held at the start of phase 1 for as long as the synchronized input stays high. It then runs the full handshake again.
- R6: The watchdog enable (status bit 3) is 0 after any reset. While it is 0, `wdt_expire_i` has no effect on any output.
- R7: With the enable at 1 and the CPU running, an expiry pulse puts `sys_rst_o` high for exactly one cycle. It sets status bit 2. The pins stay at 2'b00 and there is no handshake.
- R8: Any reset (power-on, external or watchdog) clears the watchdog enable.
- R9: A write while `cpu_run_o`=1 clears each cause bit whose data bit is 1 and keeps the ones whose data bit is 0. It also loads bit 3 from data bit 3. Writes while `cpu_run_o`=0 are ignored.
- R10: A power-on reset makes the status word 4'b0001, whatever cause bits were set before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sleep clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| xres_i | input | 1 | External reset pin, active high, asynchronous |
| wdt_expire_i | input | 1 | Watchdog expiry pulse |
| wr_en_i | input | 1 | Status word write strobe |
| wr_data_i | input | 4 | Write data: [2:0] write-one-to-clear causes, [3] watchdog enable |
| status_o | output | 4 | Cause flags [2:0] and watchdog enable [3] |
| sys_rst_o | output | 1 | System reset, active high |
| cpu_run_o | output | 1 | CPU released |
| pin0_mode_o | output | 2 | Handshake pin 0 drive mode |
| pin1_mode_o | output | 2 | Handshake pin 1 drive mode |
| gpio_hiz_o | output | 1 | Request that all other GPIOs float |

## Verification
Some rules are checked by the assertions on every cycle:
- a released CPU goes with floating pins and no system reset;
- strong-high on pin 0 is only ever paired with resistive-low on pin 1;
- leaving the floating state must always pass through strong-high;
- the watchdog enable is never set while the system is in reset;
- the held external reset forces phase 1;
- write-one-to-clear takes effect.

Exact phase lengths, the three-edge latency of the external reset, the one-cycle watchdog pulse, and the value of the status word after each kind of reset are shown only by the bench's timed scenarios.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int STATUS_W   = 4;
    localparam int CAUSE_W    = 3;
    localparam int BIT_POR    = 0;
    localparam int BIT_XRES   = 1;
    localparam int BIT_WDR    = 2;
    localparam int BIT_WDT_EN = 3;

    typedef enum logic [1:0] {
        DRV_HIZ       = 2'b00,
        DRV_RES_LO    = 2'b01,
        DRV_STRONG_HI = 2'b10
    } drv_mode_e;

    typedef enum logic [1:0] {
        ST_PH1 = 2'd0,
        ST_PH2 = 2'd1,
        ST_RUN = 2'd2,
        ST_WDR = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [CAUSE_W-1:0] cause;
        logic               wdt_en;
    } flag_regs_t;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) chain_q <= '0;
        else       chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int PHASE_CYCLES = 256
) (
    input  logic      clk_i,
    input  logic      por_i,
    input  logic      xres_sync_i,
    input  logic      wdt_fire_i,
    output logic      wdt_take_o,
    output logic      sys_rst_o,
    output logic      cpu_run_o,
    output drv_mode_e pin0_mode_o,
    output drv_mode_e pin1_mode_o
);
    localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYCLES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_PH1: begin
                if (seq_q.cnt == CNT_LAST) begin
                    seq_d.state = ST_PH2;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            ST_PH2: begin
                if (seq_q.cnt == CNT_LAST) begin
                    seq_d.state = ST_RUN;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            ST_RUN: begin
                if (wdt_fire_i) seq_d.state = ST_WDR;
            end
            ST_WDR: begin
                seq_d.state = ST_RUN;
            end
            default: seq_d.state = ST_PH1;
        endcase
        if (xres_sync_i) begin
            seq_d.state = ST_PH1;
            seq_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            seq_q.state <= ST_PH1;
            seq_q.cnt   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        wdt_take_o  = (seq_q.state == ST_RUN) && wdt_fire_i && !xres_sync_i;
        cpu_run_o   = (seq_q.state == ST_RUN);
        sys_rst_o   = !cpu_run_o;
        pin0_mode_o = DRV_HIZ;
        pin1_mode_o = DRV_HIZ;
        if (seq_q.state == ST_PH1) begin
            pin0_mode_o = DRV_STRONG_HI;
            pin1_mode_o = DRV_RES_LO;
        end else if (seq_q.state == ST_PH2) begin
            pin0_mode_o = DRV_RES_LO;
            pin1_mode_o = DRV_RES_LO;
        end
    end
endmodule

// File: rtl/rstseq_flags.sv
module rstseq_flags
    import rstseq_pkg::*;
(
    input  logic                clk_i,
    input  logic                por_i,
    input  logic                xres_sync_i,
    input  logic                wdt_take_i,
    input  logic                cpu_run_i,
    input  logic                wr_en_i,
    input  logic [STATUS_W-1:0] wr_data_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                wdt_en_o
);
    flag_regs_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (cpu_run_i && wr_en_i) begin
            flg_d.cause  = flg_q.cause & ~wr_data_i[CAUSE_W-1:0];
            flg_d.wdt_en = wr_data_i[BIT_WDT_EN];
        end
        if (wdt_take_i) begin
            flg_d.cause[BIT_WDR] = 1'b1;
            flg_d.wdt_en         = 1'b0;
        end
        if (xres_sync_i) begin
            flg_d.cause[BIT_XRES] = 1'b1;
            flg_d.wdt_en          = 1'b0;
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            flg_q.cause  <= CAUSE_W'(1) << BIT_POR;
            flg_q.wdt_en <= 1'b0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign status_o = {flg_q.wdt_en, flg_q.cause};
    assign wdt_en_o = flg_q.wdt_en;
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int PHASE_CYCLES = 256,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk_i,
    input  logic                por_i,
    input  logic                xres_i,
    input  logic                wdt_expire_i,
    input  logic                wr_en_i,
    input  logic [STATUS_W-1:0] wr_data_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                sys_rst_o,
    output logic                cpu_run_o,
    output logic [1:0]          pin0_mode_o,
    output logic [1:0]          pin1_mode_o,
    output logic                gpio_hiz_o
);
    logic      xres_sync_w;
    logic      wdt_en_w;
    logic      wdt_take_w;
    drv_mode_e pin0_w, pin1_w;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .por_i   (por_i),
        .async_i (xres_i),
        .sync_o  (xres_sync_w)
    );

    rstseq_fsm #(.PHASE_CYCLES(PHASE_CYCLES)) u_fsm (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .xres_sync_i (xres_sync_w),
        .wdt_fire_i  (wdt_expire_i && wdt_en_w),
        .wdt_take_o  (wdt_take_w),
        .sys_rst_o   (sys_rst_o),
        .cpu_run_o   (cpu_run_o),
        .pin0_mode_o (pin0_w),
        .pin1_mode_o (pin1_w)
    );

    rstseq_flags u_flags (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .xres_sync_i (xres_sync_w),
        .wdt_take_i  (wdt_take_w),
        .cpu_run_i   (cpu_run_o),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .status_o    (status_o),
        .wdt_en_o    (wdt_en_w)
    );

    assign pin0_mode_o = pin0_w;
    assign pin1_mode_o = pin1_w;
    assign gpio_hiz_o  = !cpu_run_o;
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
    input logic       clk_i,
    input logic       por_i,
    input logic       xres_sync,
    input logic       wr_en_i,
    input logic [3:0] wr_data_i,
    input logic [3:0] status_o,
    input logic       sys_rst_o,
    input logic       cpu_run_o,
    input logic [1:0] pin0_mode_o,
    input logic [1:0] pin1_mode_o,
    input logic       gpio_hiz_o
);
    // R4: released CPU means floating pins, no reset, GPIOs not held
    a_r4_run_pins_float: assert property (@(posedge clk_i) disable iff (por_i)
        cpu_run_o |-> (pin0_mode_o == 2'b00 && pin1_mode_o == 2'b00 && !sys_rst_o && !gpio_hiz_o));

    // R2: strong high on pin 0 only during phase 1 pairing
    a_r2_phase1_pairing: assert property (@(posedge clk_i) disable iff (por_i)
        (pin0_mode_o == 2'b10) |-> (pin1_mode_o == 2'b01 && sys_rst_o));

    // R7: leaving high-impedance always enters phase 1 (watchdog never starts the pins)
    a_r7_pins_start_phase1: assert property (@(posedge clk_i) disable iff (por_i)
        ($past(pin0_mode_o) == 2'b00 && pin0_mode_o != 2'b00) |-> (pin0_mode_o == 2'b10));

    // R3: phase 2 is entered only from phase 1
    a_r3_phase2_from_phase1: assert property (@(posedge clk_i) disable iff (por_i)
        ($past(pin0_mode_o) != 2'b01 && pin0_mode_o == 2'b01) |-> ($past(pin0_mode_o) == 2'b10));

    // R8: enable never set while in reset
    a_r8_enable_off_in_reset: assert property (@(posedge clk_i) disable iff (por_i)
        sys_rst_o |-> !status_o[3]);

    // R5: held external reset forces phase 1 and its flag
    a_r5_xres_forces_phase1: assert property (@(posedge clk_i) disable iff (por_i)
        xres_sync |=> (pin0_mode_o == 2'b10 && status_o[1]));

    // R9: write-one-to-clear on the power-on flag
    a_r9_w1c_por: assert property (@(posedge clk_i) disable iff (por_i)
        (wr_en_i && cpu_run_o && wr_data_i[0] && !xres_sync) |=> !status_o[0]);
endmodule

bind rstseq_top rstseq_checker u_chk (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .xres_sync   (xres_sync_w),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .status_o    (status_o),
    .sys_rst_o   (sys_rst_o),
    .cpu_run_o   (cpu_run_o),
    .pin0_mode_o (pin0_mode_o),
    .pin1_mode_o (pin1_mode_o),
    .gpio_hiz_o  (gpio_hiz_o)
);

// File: tb/rstseq_top_tb_top.sv
module rstseq_top_tb_top;
    localparam int PH = 256;

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       xres_i = 1'b0;
    logic       wdt_expire_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] wr_data_i = 4'd0;
    logic [3:0] status_o;
    logic       sys_rst_o, cpu_run_o, gpio_hiz_o;
    logic [1:0] pin0_mode_o, pin1_mode_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int         at;
        logic [3:0] st;
        logic       sr;
        logic       cr;
        logic [1:0] p0;
        logic [1:0] p1;
        logic       hz;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rstseq_top #(.PHASE_CYCLES(PH)) dut_i (
        .clk_i(clk), .por_i(por_i), .xres_i(xres_i), .wdt_expire_i(wdt_expire_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .status_o(status_o),
        .sys_rst_o(sys_rst_o), .cpu_run_o(cpu_run_o), .pin0_mode_o(pin0_mode_o),
        .pin1_mode_o(pin1_mode_o), .gpio_hiz_o(gpio_hiz_o)
    );

    task automatic expect_in(input int d, input logic [3:0] st, input logic sr, input logic cr,
                             input logic [1:0] p0, input logic [1:0] p1, input logic hz,
                             input string tag);
        exp_t e;
        e.at = cyc + d; e.st = st; e.sr = sr; e.cr = cr;
        e.p0 = p0; e.p1 = p1; e.hz = hz; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic drain();
        while (sb_q.size() > 0) step(1);
    endtask

    // monitor: pops expected items and compares at their cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (e.at < cyc) begin
                errors++;
                $display("FAIL %s: expected item for cycle %0d missed (now %0d)", e.tag, e.at, cyc);
            end else if (status_o !== e.st || sys_rst_o !== e.sr || cpu_run_o !== e.cr ||
                         pin0_mode_o !== e.p0 || pin1_mode_o !== e.p1 || gpio_hiz_o !== e.hz) begin
                errors++;
                $display("FAIL %s @%0d: got st=%b rst=%b run=%b p0=%b p1=%b hz=%b, expected st=%b rst=%b run=%b p0=%b p1=%b hz=%b",
                         e.tag, cyc, status_o, sys_rst_o, cpu_run_o, pin0_mode_o, pin1_mode_o, gpio_hiz_o,
                         e.st, e.sr, e.cr, e.p0, e.p1, e.hz);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 / R10: reset state during power-on
        step(2);
        expect_in(1, 4'b0001, 1, 0, 2'b10, 2'b01, 1, "R1_por_hold_R10");
        step(1);
        por_i = 1'b0;
        expect_in(1,      4'b0001, 1, 0, 2'b10, 2'b01, 1, "R1_after_release");
        expect_in(PH-1,   4'b0001, 1, 0, 2'b10, 2'b01, 1, "R2_phase1_end");
        expect_in(PH,     4'b0001, 1, 0, 2'b01, 2'b01, 1, "R3_phase2_start");
        expect_in(2*PH-1, 4'b0001, 1, 0, 2'b01, 2'b01, 1, "R3_phase2_end");
        expect_in(2*PH,   4'b0001, 0, 1, 2'b00, 2'b00, 0, "R4_run");
        drain();

        // R6: expiry ignored while enable is 0
        wdt_expire_i = 1'b1;
        expect_in(1, 4'b0001, 0, 1, 2'b00, 2'b00, 0, "R6_wdt_disabled");
        step(1);
        wdt_expire_i = 1'b0;
        drain();

        // R9: clear power-on flag, then enable watchdog
        wr_en_i = 1'b1; wr_data_i = 4'b0001;
        expect_in(1, 4'b0000, 0, 1, 2'b00, 2'b00, 0, "R9_w1c_por");
        step(1);
        wr_data_i = 4'b1000;
        expect_in(1, 4'b1000, 0, 1, 2'b00, 2'b00, 0, "R9_enable_write");
        step(1);
        wr_en_i = 1'b0;
        drain();

        // R7 / R8: watchdog reset, one cycle, no handshake
        wdt_expire_i = 1'b1;
        expect_in(1, 4'b0100, 1, 0, 2'b00, 2'b00, 1, "R7_wdr_pulse_R8");
        expect_in(2, 4'b0100, 0, 1, 2'b00, 2'b00, 0, "R7_wdr_release");
        step(1);
        wdt_expire_i = 1'b0;
        drain();

        // R5: external reset with three-edge latency
        wr_en_i = 1'b1; wr_data_i = 4'b1000;
        step(1);
        wr_en_i = 1'b0;
        xres_i = 1'b1;
        expect_in(2, 4'b1100, 0, 1, 2'b00, 2'b00, 0, "R5_latency_before");
        expect_in(3, 4'b0110, 1, 0, 2'b10, 2'b01, 1, "R5_xres_entry_R8");
        step(4);
        // R9: write while held in reset is ignored
        wr_en_i = 1'b1; wr_data_i = 4'b1111;
        expect_in(1, 4'b0110, 1, 0, 2'b10, 2'b01, 1, "R9_write_ignored");
        step(1);
        wr_en_i = 1'b0; wr_data_i = 4'b0000;
        step(6);
        xres_i = 1'b0;
        expect_in(PH+1, 4'b0110, 1, 0, 2'b10, 2'b01, 1, "R5_phase1_end");
        expect_in(PH+2, 4'b0110, 1, 0, 2'b01, 2'b01, 1, "R5_phase2_start");
        expect_in(2*PH+1, 4'b0110, 1, 0, 2'b01, 2'b01, 1, "R5_phase2_end");
        expect_in(2*PH+2, 4'b0110, 0, 1, 2'b00, 2'b00, 0, "R5_run");
        drain();

        // R9: partial clear and a zero write
        wr_en_i = 1'b1; wr_data_i = 4'b0010;
        expect_in(1, 4'b0100, 0, 1, 2'b00, 2'b00, 0, "R9_partial_clear");
        step(1);
        wr_data_i = 4'b0000;
        expect_in(1, 4'b0100, 0, 1, 2'b00, 2'b00, 0, "R9_zero_write");
        step(1);
        wr_en_i = 1'b0;
        drain();

        // R10: second power-on overrides other causes
        por_i = 1'b1;
        expect_in(1, 4'b0001, 1, 0, 2'b10, 2'b01, 1, "R10_por_again");
        step(2);
        por_i = 1'b0;
        expect_in(2*PH-1, 4'b0001, 1, 0, 2'b01, 2'b01, 1, "R3_second_phase2");
        expect_in(2*PH,   4'b0001, 0, 1, 2'b00, 2'b00, 0, "R4_second_run");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule